// File: doc/BRIEF.md
# Census Transform Stereo Matching Cost

This block turns two rectified 8-bit image streams, a base view and a match view, into a vector of stereo matching costs per pixel. Both streams arrive together in raster order, one pixel per clock, qualified by a single valid strobe. A frame-start strobe marks the first pixel of a frame. For each view the block keeps a few image rows in a line store and a square neighbourhood in a register window. From the window it forms a census code: one bit per neighbour, set when the centre is brighter than that neighbour.

The base code of the current centre pixel is compared at the same time with the match codes of the same column and of the DMAX-1 columns to its left. Each comparison yields a Hamming distance. A short history register of recent match codes supplies all the shifted match codes, so a full cost vector leaves the block every clock once the window has filled. Where the neighbourhood would reach past the image border, or the shifted match column is not a valid centre, the cost is forced to its largest value. Downstream aggregation can then treat those entries as unusable.

The image width, window size and disparity count are elaboration parameters. The image height is not needed, because the output valid strobe already marks which pixel each vector belongs to.

Top module: `census_cost_top`

## Requirements
- R1: For each accepted pixel whose index n in the current frame (counted from 0 in raster order) is at least HALF*IMG_W+HALF, where HALF = WIN/2, valid_o is high exactly once, two clocks after the edge that accepts the pixel. The vector then belongs to the centre pixel at index n-(HALF*IMG_W+HALF). At every other time valid_o is low, including after reset.
- R2: The census code has WIN*WIN-1 bits, one per window position other than the centre. A bit is 1 only when the centre intensity is strictly greater than that neighbour. The cost is the number of bit positions in which two codes differ.
- R3: The cost for disparity d sits at cost_o[d*COST_W +: COST_W], with COST_W = clog2(WIN*WIN). It compares the base code centred at column x with the match code centred at column x-d in the same row, for d from 0 to DMAX-1.
- R4: When the centre row is below HALF, or the centre column is below HALF or above IMG_W-1-HALF, every cost of the vector equals WIN*WIN-1.
- R5: When x-d is below HALF, the cost for disparity d equals WIN*WIN-1.
- R6: A pixel accepted with sof_i high has index 0, whatever came before it, and the first pixel after reset also has index 0. Pixels of an abandoned partial frame do not affect any cost of the next frame.
- R7: Cycles with valid_i low leave the position and all stored pixels unchanged and do not alter the two-clock latency. Pixels on consecutive cycles are all accepted.
- R8: Every cost reported with valid_o high is at most WIN*WIN-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Base and match pixels present this cycle |
| sof_i | input | 1 | First pixel of a frame, qualified by valid_i |
| base_pix_i | input | 8 | Base image intensity |
| match_pix_i | input | 8 | Match image intensity |
| valid_o | output | 1 | Cost vector present this cycle |
| cost_o | output | DMAX*clog2(WIN*WIN) | Packed costs, disparity 0 in the lowest slice |

## Verification
The assertions assume that sof_i has meaning only together with valid_i, and that a frame-start pixel cannot produce an output. The stimulus therefore raises sof_i only on the first valid pixel of each frame. The output timing checks count pixels since the last frame start, so they also rely on the image width matching IMG_W. The bench drives only whole rows of IMG_W pixels, except for one frame that is deliberately abandoned and then replaced by a new frame start. Gaps in valid_i are inserted at random, so the checks cover both stalled and back-to-back input.

// File: rtl/census_pkg.sv
package census_pkg;
  localparam int PIX_W = 8;
  typedef logic [PIX_W-1:0] pix_t;

  function automatic int code_bits(input int win);
    return win * win - 1;
  endfunction

  function automatic int cost_bits(input int win);
    return $clog2(win * win);
  endfunction
endpackage

// File: rtl/cen_pos_track.sv
module cen_pos_track #(
  parameter int IMG_W = 16,
  parameter int WIN   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     valid_i,
  input  logic                     sof_i,
  output logic [$clog2(IMG_W)-1:0] col_o,
  output logic [$clog2(IMG_W)-1:0] cx_o,
  output logic                     emit_o,
  output logic                     top_o
);
  localparam int HALF    = WIN / 2;
  localparam int COL_W   = $clog2(IMG_W);
  localparam int ROW_MAX = 2 * HALF + 1;
  localparam int ROW_W   = $clog2(ROW_MAX + 1);

  logic [COL_W-1:0] col_q, cur_col;
  logic [ROW_W-1:0] row_q, cur_row;
  logic             wrap;

  assign cur_col = sof_i ? '0 : col_q;
  assign cur_row = sof_i ? '0 : row_q;
  assign wrap    = cur_col < COL_W'(HALF);
  assign col_o   = cur_col;

  // centre trails input by HALF rows and HALF columns; wrap lands on previous row
  always_comb begin
    if (wrap) begin
      cx_o   = cur_col + COL_W'(IMG_W - HALF);
      emit_o = cur_row >= ROW_W'(HALF + 1);
      top_o  = cur_row < ROW_W'(2 * HALF + 1);
    end else begin
      cx_o   = cur_col - COL_W'(HALF);
      emit_o = cur_row >= ROW_W'(HALF);
      top_o  = cur_row < ROW_W'(2 * HALF);
    end
  end

  // row count saturates: only the first rows matter for border decisions
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q <= '0;
      row_q <= '0;
    end else if (valid_i) begin
      if (cur_col == COL_W'(IMG_W - 1)) begin
        col_q <= '0;
        row_q <= (cur_row == ROW_W'(ROW_MAX)) ? cur_row : cur_row + 1'b1;
      end else begin
        col_q <= cur_col + 1'b1;
        row_q <= cur_row;
      end
    end
  end
endmodule

// File: rtl/cen_window.sv
module cen_window
  import census_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int WIN   = 5
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     adv_i,
  input  logic [$clog2(IMG_W)-1:0] col_i,
  input  logic [PIX_W-1:0]         pix_i,
  output logic [WIN*WIN-2:0]       code_o
);
  localparam int HALF = WIN / 2;
  localparam int CTR  = HALF * WIN + HALF;

  pix_t lb_q  [WIN-1][IMG_W];  // row 0 oldest
  pix_t win_q [WIN][WIN];      // [row][col], col WIN-1 newest
  pix_t col_vec [WIN];

  always_comb begin
    for (int r = 0; r < WIN - 1; r++) col_vec[r] = lb_q[r][col_i];
    col_vec[WIN-1] = pix_i;
  end

  always_ff @(posedge clk_i) begin
    if (adv_i) begin
      for (int r = 0; r < WIN - 2; r++) lb_q[r][col_i] <= lb_q[r+1][col_i];
      lb_q[WIN-2][col_i] <= pix_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < WIN; r++)
        for (int c = 0; c < WIN; c++) win_q[r][c] <= '0;
    end else if (adv_i) begin
      for (int r = 0; r < WIN; r++) begin
        for (int c = 0; c < WIN - 1; c++) win_q[r][c] <= win_q[r][c+1];
        win_q[r][WIN-1] <= col_vec[r];
      end
    end
  end

  for (genvar gr = 0; gr < WIN; gr++) begin : g_row
    for (genvar gc = 0; gc < WIN; gc++) begin : g_col
      localparam int POS = gr * WIN + gc;
      if (POS != CTR) begin : g_bit
        localparam int BI = (POS < CTR) ? POS : POS - 1;
        assign code_o[BI] = win_q[HALF][HALF] > win_q[gr][gc];
      end
    end
  end
endmodule

// File: rtl/cen_cost_array.sv
module cen_cost_array
  import census_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int WIN   = 5,
  parameter int DMAX  = 8
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic                                adv_i,
  input  logic                                vld_i,
  input  logic                                top_i,
  input  logic [$clog2(IMG_W)-1:0]            cx_i,
  input  logic [WIN*WIN-2:0]                  base_code_i,
  input  logic [WIN*WIN-2:0]                  match_code_i,
  output logic                                valid_o,
  output logic [DMAX*$clog2(WIN*WIN)-1:0]     cost_o
);
  localparam int HALF   = WIN / 2;
  localparam int COL_W  = $clog2(IMG_W);
  localparam int CODE_W = code_bits(WIN);
  localparam int COST_W = cost_bits(WIN);
  localparam int RIGHT  = IMG_W - 1 - HALF;

  typedef logic [CODE_W-1:0] code_t;
  typedef logic [COST_W-1:0] cost_t;

  code_t            hist_q [DMAX];  // hist_q[d]: match code d centres back
  code_t            base_q;
  logic             s2_vld, s2_top;
  logic [COL_W-1:0] s2_cx;
  cost_t            cost_q [DMAX];

  function automatic cost_t ones(input code_t v);
    cost_t n = '0;
    for (int i = 0; i < CODE_W; i++) n = n + cost_t'(v[i]);
    return n;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int d = 0; d < DMAX; d++) hist_q[d] <= '0;
      base_q <= '0;
      s2_vld <= 1'b0;
      s2_top <= 1'b0;
      s2_cx  <= '0;
    end else begin
      s2_vld <= vld_i;
      if (adv_i) begin
        hist_q[0] <= match_code_i;
        for (int d = 1; d < DMAX; d++) hist_q[d] <= hist_q[d-1];
        base_q <= base_code_i;
      end
      if (vld_i) begin
        s2_top <= top_i;
        s2_cx  <= cx_i;
      end
    end
  end

  for (genvar gd = 0; gd < DMAX; gd++) begin : g_disp
    logic  bad;
    cost_t cost_d;
    assign bad    = s2_top || (int'(s2_cx) > RIGHT) || (int'(s2_cx) < HALF + gd);
    assign cost_d = bad ? cost_t'(CODE_W) : ones(base_q ^ hist_q[gd]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)     cost_q[gd] <= '0;
      else if (s2_vld) cost_q[gd] <= cost_d;
    end

    assign cost_o[gd*COST_W +: COST_W] = cost_q[gd];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_o <= 1'b0;
    else         valid_o <= s2_vld;
  end
endmodule

// File: rtl/census_cost_top.sv
module census_cost_top
  import census_pkg::*;
#(
  parameter int IMG_W = 16,
  parameter int WIN   = 5,
  parameter int DMAX  = 8
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            valid_i,
  input  logic                            sof_i,
  input  logic [7:0]                      base_pix_i,
  input  logic [7:0]                      match_pix_i,
  output logic                            valid_o,
  output logic [DMAX*$clog2(WIN*WIN)-1:0] cost_o
);
  localparam int COL_W  = $clog2(IMG_W);
  localparam int CODE_W = code_bits(WIN);

  logic [COL_W-1:0]  cur_col, cx0, s1_cx;
  logic              emit0, top0;
  logic              s1_adv, s1_vld, s1_top;
  logic [CODE_W-1:0] code_b, code_m;

  cen_pos_track #(.IMG_W(IMG_W), .WIN(WIN)) u_pos (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .valid_i(valid_i),
    .sof_i  (sof_i),
    .col_o  (cur_col),
    .cx_o   (cx0),
    .emit_o (emit0),
    .top_o  (top0)
  );

  cen_window #(.IMG_W(IMG_W), .WIN(WIN)) u_win_base (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (valid_i),
    .col_i (cur_col),
    .pix_i (base_pix_i),
    .code_o(code_b)
  );

  cen_window #(.IMG_W(IMG_W), .WIN(WIN)) u_win_match (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (valid_i),
    .col_i (cur_col),
    .pix_i (match_pix_i),
    .code_o(code_m)
  );

  // stage 1 tags the window that was just loaded
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_adv <= 1'b0;
      s1_vld <= 1'b0;
      s1_top <= 1'b0;
      s1_cx  <= '0;
    end else begin
      s1_adv <= valid_i;
      s1_vld <= valid_i && emit0;
      if (valid_i) begin
        s1_top <= top0;
        s1_cx  <= cx0;
      end
    end
  end

  cen_cost_array #(.IMG_W(IMG_W), .WIN(WIN), .DMAX(DMAX)) u_cost (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (s1_adv),
    .vld_i       (s1_vld),
    .top_i       (s1_top),
    .cx_i        (s1_cx),
    .base_code_i (code_b),
    .match_code_i(code_m),
    .valid_o     (valid_o),
    .cost_o      (cost_o)
  );
endmodule

// File: rtl/census_cost_chk.sv
module census_cost_chk #(
  parameter int IMG_W = 16,
  parameter int WIN   = 5,
  parameter int DMAX  = 8
) (
  input logic                            clk_i,
  input logic                            rst_ni,
  input logic                            valid_i,
  input logic                            sof_i,
  input logic                            valid_o,
  input logic [DMAX*$clog2(WIN*WIN)-1:0] cost_o
);
  localparam int HALF   = WIN / 2;
  localparam int OFF    = HALF * IMG_W + HALF;
  localparam int CODE_W = WIN * WIN - 1;
  localparam int COST_W = $clog2(WIN * WIN);

  int unsigned cnt_q, idx_now;
  logic        due_now;

  assign idx_now = sof_i ? 0 : cnt_q;
  assign due_now = valid_i && (idx_now >= OFF);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= 0;
    else if (valid_i) cnt_q <= (idx_now < OFF) ? idx_now + 1 : idx_now;
  end

  // R1
  out_when_due_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(due_now, 3) |-> valid_o);

  // R1
  no_spurious_out_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $past(due_now, 3));

  // R6
  sof_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(valid_i && sof_i, 3) |-> !valid_o);

  // R7
  stall_silent_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!valid_i, 3) |-> !valid_o);

  for (genvar gd = 0; gd < DMAX; gd++) begin : g_rng
    // R8
    cost_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      valid_o |-> (int'(cost_o[gd*COST_W +: COST_W]) <= CODE_W));
  end
endmodule

bind census_cost_top census_cost_chk #(.IMG_W(IMG_W), .WIN(WIN), .DMAX(DMAX)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .valid_i(valid_i),
  .sof_i  (sof_i),
  .valid_o(valid_o),
  .cost_o (cost_o)
);

// File: tb/census_cost_tb.sv
module census_cost_top_tb_top;
  localparam int W      = 16;
  localparam int WIN    = 5;
  localparam int DMAX   = 8;
  localparam int HALF   = WIN / 2;
  localparam int CODE_W = WIN * WIN - 1;
  localparam int COST_W = $clog2(WIN * WIN);
  localparam int OFF    = HALF * W + HALF;
  localparam int MAXH   = 12;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic valid_i = 1'b0;
  logic sof_i = 1'b0;
  logic [7:0] base_pix_i = '0;
  logic [7:0] match_pix_i = '0;
  logic valid_o;
  logic [DMAX*COST_W-1:0] cost_o;

  always #10 clk = ~clk;

  census_cost_top #(.IMG_W(W), .WIN(WIN), .DMAX(DMAX)) dut_i (
    .clk_i      (clk),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .sof_i      (sof_i),
    .base_pix_i (base_pix_i),
    .match_pix_i(match_pix_i),
    .valid_o    (valid_o),
    .cost_o     (cost_o)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;
  string phase = "R3";

  int bimg [MAXH][W];
  int mimg [MAXH][W];
  int n_pix = 0;

  int                     due_q [$];
  int                     cx_q  [$];
  int                     cy_q  [$];
  string                  tag_q [$];
  logic [DMAX*COST_W-1:0] vec_q [$];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [CODE_W-1:0] cen(input bit mat, input int cx, input int cy);
    logic [CODE_W-1:0] v = '0;
    int k = 0;
    int ctr = mat ? mimg[cy][cx] : bimg[cy][cx];
    for (int dy = -HALF; dy <= HALF; dy++)
      for (int dx = -HALF; dx <= HALF; dx++) begin
        int nb;
        if (dy == 0 && dx == 0) continue;
        nb = mat ? mimg[cy+dy][cx+dx] : bimg[cy+dy][cx+dx];
        v[k] = ctr > nb;
        k++;
      end
    return v;
  endfunction

  task automatic model(input bit sof, input int b, input int m);
    if (sof) n_pix = 0;
    bimg[n_pix/W][n_pix%W] = b;
    mimg[n_pix/W][n_pix%W] = m;
    if (n_pix >= OFF) begin
      int ctr = n_pix - OFF;
      int cx = ctr % W;
      int cy = ctr / W;
      logic [DMAX*COST_W-1:0] vec = '0;
      for (int d = 0; d < DMAX; d++) begin
        int e;
        if (cy < HALF || cx > W - 1 - HALF || cx - d < HALF) e = CODE_W;
        else e = $countones(cen(1'b0, cx, cy) ^ cen(1'b1, cx - d, cy));
        vec[d*COST_W +: COST_W] = COST_W'(e);
      end
      due_q.push_back(cyc + 3);
      cx_q.push_back(cx);
      cy_q.push_back(cy);
      tag_q.push_back(phase);
      vec_q.push_back(vec);
    end
    if (n_pix < MAXH * W - 1) n_pix++;
  endtask

  task automatic send(input bit sof, input int b, input int m);
    @(negedge clk);
    valid_i = 1'b1;
    sof_i = sof;
    base_pix_i = 8'(b);
    match_pix_i = 8'(m);
    model(sof, b, m);
  endtask

  task automatic idle(input int n);
    repeat (n) begin
      @(negedge clk);
      valid_i = 1'b0;
      sof_i = 1'b0;
    end
  endtask

  // mode 0: match = base shifted by 3; 1: random; 2: flat; 3: narrow range with ties
  task automatic run_frame(input int rows, input int mode, input int gap, input int npix);
    int bf [MAXH][W];
    int mf [MAXH][W];
    for (int y = 0; y < rows; y++)
      for (int x = 0; x < W; x++) begin
        case (mode)
          0: bf[y][x] = int'($urandom_range(0, 255));
          1: begin bf[y][x] = int'($urandom_range(0, 255)); mf[y][x] = int'($urandom_range(0, 255)); end
          2: begin bf[y][x] = 77; mf[y][x] = 77; end
          default: begin bf[y][x] = int'($urandom_range(0, 3)); mf[y][x] = int'($urandom_range(0, 3)); end
        endcase
      end
    if (mode == 0)
      for (int y = 0; y < rows; y++)
        for (int x = 0; x < W; x++)
          mf[y][x] = (x + 3 < W) ? bf[y][x+3] : int'($urandom_range(0, 255));
    for (int i = 0; i < npix; i++) begin
      if (gap > 0) while (int'($urandom_range(0, 99)) < gap) idle(1);
      send(i == 0, bf[i/W][i%W], mf[i/W][i%W]);
    end
  endtask

  always @(negedge clk) begin
    if (rst_ni && !done) begin
      if (due_q.size() > 0 && due_q[0] == cyc) begin
        checks++;
        if (valid_o !== 1'b1) begin
          errors++;
          $display("FAIL R1 %s: valid_o got %0b expected 1 at cycle %0d", tag_q[0], valid_o, cyc);
        end else begin
          for (int d = 0; d < DMAX; d++) begin
            int got = int'(cost_o[d*COST_W +: COST_W]);
            int exp = int'(vec_q[0][d*COST_W +: COST_W]);
            string why;
            if (cy_q[0] < HALF || cx_q[0] > W - 1 - HALF || cx_q[0] < HALF) why = "R4";
            else if (cx_q[0] - d < HALF) why = "R5";
            else why = "R2/R3";
            checks++;
            if (got != exp) begin
              errors++;
              $display("FAIL %s %s: x=%0d y=%0d d=%0d cost got %0d expected %0d",
                       why, tag_q[0], cx_q[0], cy_q[0], d, got, exp);
            end
            checks++;
            if (got > CODE_W) begin
              errors++;
              $display("FAIL R8: d=%0d cost got %0d expected at most %0d", d, got, CODE_W);
            end
          end
        end
        void'(due_q.pop_front());
        void'(cx_q.pop_front());
        void'(cy_q.pop_front());
        void'(tag_q.pop_front());
        void'(vec_q.pop_front());
      end else if (valid_o) begin
        checks++;
        errors++;
        $display("FAIL R1: valid_o got 1 expected 0 at cycle %0d", cyc);
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL R1: watchdog got hang expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    checks++;
    if (valid_o !== 1'b0) begin
      errors++;
      $display("FAIL R1: valid_o after reset got %0b expected 0", valid_o);
    end
    // R3: shifted views give zero cost at disparity 3 in the interior
    phase = "R3";
    run_frame(8, 0, 0, 8 * W);
    idle(4);
    // R7: random stalls between pixels
    phase = "R7";
    run_frame(8, 1, 40, 8 * W);
    // R6: abandoned frame followed at once by a new frame start
    phase = "R6";
    run_frame(8, 1, 0, 50);
    run_frame(8, 3, 0, 8 * W);
    // R2: flat image and tie-heavy image, R4/R5 borders in every frame
    phase = "R2";
    run_frame(8, 2, 0, 8 * W);
    run_frame(6, 3, 10, 6 * W);
    idle(8);
    checks++;
    if (due_q.size() != 0) begin
      errors++;
      $display("FAIL R1: pending outputs got %0d expected 0", due_q.size());
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule